// File: doc/BRIEF.md
# AXI Write Transaction Pacer

This block decides when each AXI write transaction of a repeated command goes out, and how many go out. A start pulse captures the configuration. The pacer then waits a programmable number of clocks and asks an address-channel stage to issue one request. After that request is accepted, it opens a beat-valid gate for the write-data stage once per data beat. It can hold the gate closed for a programmable number of idle clocks between beats.

The run length can be set in three ways:
- a plain transaction count;
- a data volume, from which the number of transactions is derived;
- endless repetition, which ends only on a stop request or a reset.

The block produces no addresses, attributes or payloads. It only sequences and paces the transactions. It raises a one-cycle done pulse when a finite run ends, and it exposes a running count of completed transactions.

Top module: `axi_wr_pacer`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `aw_req_o`, `wbeat_en_o`, `busy_o` and `done_o` are 0 and `txn_cnt_o` is 0. A reset in the middle of a run returns the block to idle.
- R2: With `mode_i` = 0 (count), a start with count N > 0 produces exactly N address handshakes (`aw_req_o` and `aw_ack_i` both high).
- R3: A start with count 0 in mode 0, or with volume 0 in mode 1, issues no request. `done_o` is high in the cycle after the start is accepted.
- R4: With `mode_i` = 1 (volume), the number of transactions is ceil(V·M / ((len+1)·2^size)). M is selected by `vol_unit_i`: 0 gives 2^10, 1 gives 2^20, 2 gives 2^30, 3 gives 1 (plain bytes).
- R5: With `mode_i[1]` = 1 (endless), transactions repeat without limit and `done_o` never rises.
- R6: Let d be the start delay. Count from the edge that accepts `start_i`, or from the edge that takes the final beat of the previous transaction. Exactly d idle cycles pass, and `aw_req_o` is high in cycle d+1.
- R7: Once raised, `aw_req_o` stays high until `aw_ack_i` is seen with it.
- R8: After each address handshake, exactly len+1 beats are offered. `wbeat_en_o` stays high until `w_ready_i` accepts the beat.
- R9: With gap g, `wbeat_en_o` is low for exactly g cycles between two beats of one transaction. With g = 0, beats are back to back. No gap follows the final beat.
- R10: `done_o` is a one-cycle pulse in the cycle after the final beat of the last counted transaction. `txn_cnt_o` clears when a start is accepted and increments by one on each final beat.
- R11: `start_i` is ignored while `busy_o` is high. The configuration is latched only when a start is accepted.
- R12: A `stop_i` seen during a start delay returns the block to idle in the next cycle. A stop seen while a request or burst is in progress lets that transaction finish, then returns to idle. A stop never raises `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture configuration and begin a run |
| stop_i | input | 1 | End the run at the next safe point |
| mode_i | input | 2 | 0 count, 1 volume, 2 or 3 endless |
| txn_num_i | input | CNT_W | Transaction count for mode 0 |
| vol_i | input | VOL_W | Volume value for mode 1 |
| vol_unit_i | input | 2 | Volume multiplier selector |
| len_i | input | LEN_W | Beats per transaction minus one |
| size_i | input | SIZE_W | log2 of bytes per beat |
| start_dly_i | input | DLY_W | Idle clocks before each request |
| beat_gap_i | input | DLY_W | Idle clocks between beats |
| aw_req_o | output | 1 | Request to the address stage |
| aw_ack_i | input | 1 | Address stage accepted the request |
| wbeat_en_o | output | 1 | Beat-valid gate for the data stage |
| w_ready_i | input | 1 | Data stage accepted the beat |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Finite run completed |
| txn_cnt_o | output | CNT_W | Completed transactions in this run |

## Verification
The assertions check four things on every cycle:
- request and beat-gate hold under backpressure;
- the presence or absence of an idle cycle right after a non-final beat;
- the shape of the done pulse and the unit step of the running count;
- that the delay timer and the remaining-work counter never underflow.

Other behaviours are visible only through the bench's scenarios:
- whole-run properties, namely the exact transaction totals for count and volume runs, including the rounding up of non-divisible volumes;
- the length of the start delay;
- the absence of done in endless runs;
- where a stop takes effect;
- that a second start is ignored.

The bench follows every cycle with a reference model under random handshake backpressure.

// File: rtl/pace_pkg.sv
package pace_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DLY,
    PH_ADDR,
    PH_BEAT,
    PH_GAP
  } phase_e;

  localparam logic [1:0] MODE_COUNT = 2'd0;
  localparam logic [1:0] MODE_VOL   = 2'd1;

  localparam logic [1:0] UNIT_KB = 2'd0;
  localparam logic [1:0] UNIT_MB = 2'd1;
  localparam logic [1:0] UNIT_GB = 2'd2;
endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         tick_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (tick_i) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == W'(1));

  assert_tmr_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> cnt_q != '0);
endmodule

// File: rtl/txn_budget.sv
module txn_budget
  import pace_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int VOL_W  = 16,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [VOL_W-1:0]  vol_i,
  input  logic [1:0]        unit_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              step_i,
  output logic              zero_o,
  output logic              last_o
);
  localparam int REM_W = (VOL_W + 30 > CNT_W) ? VOL_W + 30 : CNT_W;
  localparam int BPT_W = LEN_W + 1 + (1 << SIZE_W) - 1;

  logic [REM_W-1:0] rem_q, step_amt, load_val;
  logic [BPT_W-1:0] bpt_q, bpt_d;
  logic             vol_mode_q, inf_q;
  logic [4:0]       shift;

  always_comb begin
    unique case (unit_i)
      UNIT_KB: shift = 5'd10;
      UNIT_MB: shift = 5'd20;
      UNIT_GB: shift = 5'd30;
      default: shift = 5'd0;
    endcase
  end

  assign bpt_d    = (BPT_W'(len_i) + BPT_W'(1)) << size_i;
  assign load_val = (mode_i == MODE_VOL) ? (REM_W'(vol_i) << shift) : REM_W'(cnt_i);
  assign zero_o   = !mode_i[1] && (load_val == '0);
  assign step_amt = vol_mode_q ? REM_W'(bpt_q) : REM_W'(1);
  // remaining work fits in one more transaction: ceil() falls out of this test
  assign last_o   = !inf_q && (rem_q <= step_amt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q      <= '0;
      bpt_q      <= '0;
      vol_mode_q <= 1'b0;
      inf_q      <= 1'b0;
    end else if (load_i) begin
      rem_q      <= load_val;
      bpt_q      <= bpt_d;
      vol_mode_q <= (mode_i == MODE_VOL);
      inf_q      <= mode_i[1];
    end else if (step_i && !inf_q) begin
      rem_q <= last_o ? '0 : rem_q - step_amt;
    end
  end

  assert_rem_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !inf_q) |-> rem_q != '0);
endmodule

// File: rtl/axi_wr_pacer.sv
module axi_wr_pacer
  import pace_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int VOL_W  = 16,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        mode_i,
  input  logic [CNT_W-1:0]  txn_num_i,
  input  logic [VOL_W-1:0]  vol_i,
  input  logic [1:0]        vol_unit_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DLY_W-1:0]  start_dly_i,
  input  logic [DLY_W-1:0]  beat_gap_i,
  output logic              aw_req_o,
  input  logic              aw_ack_i,
  output logic              wbeat_en_o,
  input  logic              w_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  txn_cnt_o
);
  phase_e           ph_q, ph_d;
  logic [LEN_W-1:0] len_q, beat_q;
  logic [DLY_W-1:0] sdly_q, gap_q, tmr_val;
  logic             tmr_load, tmr_tick, tmr_last;
  logic             bud_load, bud_step, bud_zero, bud_last;
  logic             done_q, done_d, stop_pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept, w_hs, last_beat, txn_end, stop_now;

  assign accept    = (ph_q == PH_IDLE) && start_i;
  assign w_hs      = (ph_q == PH_BEAT) && w_ready_i;
  assign last_beat = (beat_q == len_q);
  assign txn_end   = w_hs && last_beat;
  assign stop_now  = stop_i || stop_pend_q;

  pace_timer #(.W(DLY_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .tick_i (tmr_tick),
    .last_o (tmr_last)
  );

  txn_budget #(
    .CNT_W(CNT_W), .VOL_W(VOL_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
  ) u_budget (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (bud_load),
    .mode_i (mode_i),
    .cnt_i  (txn_num_i),
    .vol_i  (vol_i),
    .unit_i (vol_unit_i),
    .len_i  (len_i),
    .size_i (size_i),
    .step_i (bud_step),
    .zero_o (bud_zero),
    .last_o (bud_last)
  );

  always_comb begin
    ph_d     = ph_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_tick = 1'b0;
    bud_load = 1'b0;
    bud_step = 1'b0;
    done_d   = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        bud_load = 1'b1;
        if (bud_zero)                done_d = 1'b1;
        else if (start_dly_i == '0)  ph_d = PH_ADDR;
        else begin
          ph_d     = PH_DLY;
          tmr_load = 1'b1;
          tmr_val  = start_dly_i;
        end
      end
      PH_DLY: begin
        if (stop_i) ph_d = PH_IDLE;
        else begin
          tmr_tick = 1'b1;
          if (tmr_last) ph_d = PH_ADDR;
        end
      end
      PH_ADDR: if (aw_ack_i) ph_d = PH_BEAT;
      PH_BEAT: if (w_ready_i) begin
        if (last_beat) begin
          bud_step = 1'b1;
          if (bud_last) begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
          end else if (stop_now)  ph_d = PH_IDLE;
          else if (sdly_q == '0)  ph_d = PH_ADDR;
          else begin
            ph_d     = PH_DLY;
            tmr_load = 1'b1;
            tmr_val  = sdly_q;
          end
        end else if (gap_q != '0) begin
          ph_d     = PH_GAP;
          tmr_load = 1'b1;
          tmr_val  = gap_q;
        end
      end
      PH_GAP: begin
        tmr_tick = 1'b1;
        if (tmr_last) ph_d = PH_BEAT;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      beat_q      <= '0;
      len_q       <= '0;
      sdly_q      <= '0;
      gap_q       <= '0;
      done_q      <= 1'b0;
      stop_pend_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      ph_q   <= ph_d;
      done_q <= done_d;
      if (accept) begin
        len_q  <= len_i;
        sdly_q <= start_dly_i;
        gap_q  <= beat_gap_i;
        cnt_q  <= '0;
      end else if (txn_end) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (ph_q == PH_ADDR)         beat_q <= '0;
      else if (w_hs && !last_beat) beat_q <= beat_q + 1'b1;
      if (ph_d == PH_IDLE)
        stop_pend_q <= 1'b0;
      else if (stop_i && (ph_q == PH_ADDR || ph_q == PH_BEAT || ph_q == PH_GAP))
        stop_pend_q <= 1'b1;
    end
  end

  assign aw_req_o   = (ph_q == PH_ADDR);
  assign wbeat_en_o = (ph_q == PH_BEAT);
  assign busy_o     = (ph_q != PH_IDLE);
  assign done_o     = done_q;
  assign txn_cnt_o  = cnt_q;

  assert_awreq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_req_o && !aw_ack_i) |=> aw_req_o);

  assert_beat_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wbeat_en_o && !w_ready_i) |=> wbeat_en_o);

  assert_gap_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_hs && !last_beat && gap_q != '0) |=> !wbeat_en_o);

  assert_back2back_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_hs && !last_beat && gap_q == '0) |=> wbeat_en_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

  assert_cnt_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txn_cnt_o) |-> (txn_cnt_o == '0 || txn_cnt_o == CNT_W'($past(txn_cnt_o) + 1'b1)));
endmodule

// File: tb/tb_axi_wr_pacer.sv
`timescale 1ns/1ps
module tb_axi_wr_pacer;
  localparam int CNT_W = 16, VOL_W = 16, LEN_W = 8, SIZE_W = 3, DLY_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic [1:0] mode = '0, unit = '0;
  logic [CNT_W-1:0] txn_num = '0;
  logic [VOL_W-1:0] vol = '0;
  logic [LEN_W-1:0] len = '0;
  logic [SIZE_W-1:0] size = '0;
  logic [DLY_W-1:0] sdly = '0, gap = '0;
  logic aw_ack = 1'b0, w_ready = 1'b0;
  logic aw_req, wbeat_en, busy, done;
  logic [CNT_W-1:0] txn_cnt;

  axi_wr_pacer #(.CNT_W(CNT_W), .VOL_W(VOL_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .DLY_W(DLY_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .mode_i(mode),
    .txn_num_i(txn_num), .vol_i(vol), .vol_unit_i(unit), .len_i(len), .size_i(size),
    .start_dly_i(sdly), .beat_gap_i(gap), .aw_req_o(aw_req), .aw_ack_i(aw_ack),
    .wbeat_en_o(wbeat_en), .w_ready_i(w_ready), .busy_o(busy), .done_o(done), .txn_cnt_o(txn_cnt)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  logic rnd_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int aw_n = 0, beat_n = 0, done_n = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // reference model: phase 0 idle, 1 delay, 2 request, 3 beat, 4 gap
  int m_ph = 0, m_tmr = 0, m_beat = 0, m_len = 0, m_sdly = 0, m_gap = 0;
  longint m_left = 0, m_cnt = 0;
  bit m_inf = 0, m_pend = 0, m_done = 0;

  task automatic m_go_delay(input int d);
    if (d == 0) m_ph = 2;
    else begin m_ph = 1; m_tmr = d; end
  endtask

  function automatic longint txn_need(input int v, input int u, input int l, input int s);
    longint bytes, bpt;
    int sh;
    sh = (u == 0) ? 10 : (u == 1) ? 20 : (u == 2) ? 30 : 0;
    bytes = longint'(v) << sh;
    bpt = longint'(l + 1) << s;
    return (bytes + bpt - 1) / bpt;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_done = 0; m_cnt = 0; m_pend = 0; m_beat = 0;
    end else begin
      m_done = 0;
      case (m_ph)
        0: if (start) begin
          m_cnt = 0; m_len = int'(len); m_sdly = int'(sdly); m_gap = int'(gap); m_inf = mode[1];
          m_left = (mode == 2'd1) ? txn_need(int'(vol), int'(unit), int'(len), int'(size)) : longint'(txn_num);
          if (!m_inf && m_left == 0) m_done = 1;
          else m_go_delay(int'(sdly));
        end
        1: if (stop) m_ph = 0;
           else begin m_tmr--; if (m_tmr == 0) m_ph = 2; end
        2: begin
          if (stop) m_pend = 1;
          if (aw_ack) begin m_ph = 3; m_beat = 0; end
        end
        3: begin
          if (stop) m_pend = 1;
          if (w_ready) begin
            if (m_beat == m_len) begin
              m_cnt = (m_cnt + 1) % 65536;
              if (!m_inf) m_left--;
              if (!m_inf && m_left == 0) begin m_done = 1; m_ph = 0; end
              else if (m_pend) m_ph = 0;
              else m_go_delay(m_sdly);
            end else begin
              m_beat++;
              if (m_gap != 0) begin m_ph = 4; m_tmr = m_gap; end
            end
          end
        end
        4: begin
          if (stop) m_pend = 1;
          m_tmr--; if (m_tmr == 0) m_ph = 3;
        end
        default: m_ph = 0;
      endcase
      if (m_ph == 0) m_pend = 0;
    end
  end

  // scenario counters on handshakes
  always @(posedge clk) begin
    if (rst_n) begin
      if (aw_req && aw_ack) aw_n++;
      if (wbeat_en && w_ready) beat_n++;
      if (done) done_n++;
    end
  end

  // backpressure drive and per-cycle comparison
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    aw_ack  = rnd_en ? lfsr[0] : 1'b1;
    w_ready = rnd_en ? (lfsr[3] | lfsr[7]) : 1'b1;
    if (rst_n) begin
      chk("R7 aw_req_o", aw_req, (m_ph == 2));
      chk("R8 wbeat_en_o", wbeat_en, (m_ph == 3));
      chk("R2 busy_o", busy, (m_ph != 0));
      chk("R10 done_o", done, m_done);
      chk("R10 txn_cnt_o", txn_cnt, m_cnt);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic clr_cnt();
    aw_n = 0; beat_n = 0; done_n = 0;
  endtask

  task automatic setup(input logic [1:0] md, input int n, input int v, input int u,
                       input int l, input int s, input int d, input int g);
    mode = md; txn_num = CNT_W'(n); vol = VOL_W'(v); unit = 2'(u);
    len = LEN_W'(l); size = SIZE_W'(s); sdly = DLY_W'(d); gap = DLY_W'(g);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 aw_req_o in reset", aw_req, 0);
    chk("R1 busy_o in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wbeat_en_o after reset", wbeat_en, 0);
    chk("R1 done_o after reset", done, 0);
    chk("R1 txn_cnt_o after reset", txn_cnt, 0);

    // R2 / R6: count mode with random backpressure, start delay measured
    rnd_en = 1'b1;
    setup(2'd0, 3, 0, 0, 2, 3, 2, 1);
    clr_cnt();
    @(negedge clk); start = 1'b1;
    t = 0;
    @(negedge clk); start = 1'b0; t = 1;
    while (!aw_req && t < 50) begin @(negedge clk); t++; end
    chk("R6 first request cycle", t, 3);
    wait_idle();
    chk("R2 address handshakes", aw_n, 3);
    chk("R8 beats total", beat_n, 9);
    chk("R10 done pulses", done_n, 1);
    chk("R10 final count", txn_cnt, 3);

    // R9: zero gap, no start delay, full throughput
    rnd_en = 1'b0;
    setup(2'd0, 2, 0, 0, 3, 2, 0, 0);
    clr_cnt();
    pulse_start();
    wait_idle();
    chk("R9 back-to-back beats", beat_n, 8);
    chk("R6 zero delay handshakes", aw_n, 2);

    // R3: zero count and zero volume
    setup(2'd0, 0, 0, 0, 0, 0, 4, 0);
    clr_cnt();
    pulse_start();
    chk("R3 done after zero count", done, 1);
    chk("R3 busy after zero count", busy, 0);
    setup(2'd1, 5, 0, 2, 0, 0, 4, 0);
    pulse_start();
    chk("R3 done after zero volume", done, 1);
    @(negedge clk);
    chk("R3 no request", aw_n, 0);

    // R4: plain bytes, non-divisible: ceil(100/32) = 4
    rnd_en = 1'b1;
    setup(2'd1, 0, 100, 3, 1, 4, 1, 2);
    clr_cnt();
    pulse_start();
    wait_idle();
    chk("R4 bytes volume transactions", aw_n, 4);
    // R4: KB unit, ceil(3072/640) = 5
    setup(2'd1, 0, 3, 0, 4, 7, 0, 0);
    clr_cnt();
    pulse_start();
    wait_idle();
    chk("R4 KB volume transactions", aw_n, 5);
    chk("R4 KB done", done_n, 1);
    // R4: MB unit, 2^20 / 32768 = 32
    rnd_en = 1'b0;
    setup(2'd1, 0, 1, 1, 255, 7, 0, 0);
    clr_cnt();
    pulse_start();
    wait_idle();
    chk("R4 MB volume transactions", aw_n, 32);

    // R11: second start while busy ignored
    rnd_en = 1'b1;
    setup(2'd0, 2, 0, 0, 1, 0, 3, 1);
    clr_cnt();
    pulse_start();
    repeat (3) @(negedge clk);
    txn_num = CNT_W'(5);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle();
    chk("R11 start ignored while busy", aw_n, 2);

    // R5 / R12: endless run, stop mid-burst
    setup(2'd2, 1, 0, 0, 2, 0, 1, 1);
    clr_cnt();
    pulse_start();
    repeat (1500) @(negedge clk);
    chk("R5 no done in endless mode", done_n, 0);
    chk("R5 still busy", busy, 1);
    for (int i = 0; i < 100; i++) begin
      if (wbeat_en) break;
      @(negedge clk);
    end
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    wait_idle();
    chk("R12 burst completes before stop", beat_n % 3, 0);
    chk("R12 no done on stop", done_n, 0);
    chk("R12 idle after stop", busy, 0);

    // R12: stop during start delay
    setup(2'd3, 0, 0, 0, 0, 0, 50, 0);
    clr_cnt();
    pulse_start();
    repeat (4) @(negedge clk);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R12 idle right after stop in delay", busy, 0);
    chk("R12 no request issued", aw_n, 0);

    // R1: reset in the middle of a run
    setup(2'd0, 9, 0, 0, 3, 0, 0, 2);
    pulse_start();
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy cleared by reset", busy, 0);
    chk("R1 count cleared by reset", txn_cnt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset release", aw_req, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule